// File: doc/BRIEF.md
# Watchdog with Shared Event-Timer Prescaler

This block pairs a watchdog with an 8-bit event timer. The two share one programmable prescaler. One assignment pin decides which side owns the prescaler. The watchdog advances only on a single-cycle tick enable that comes from an independent free-running source. It therefore keeps counting while the core is in sleep.

When the device is awake, a watchdog expiry produces a one-cycle reset request. When the device is asleep, the expiry produces a one-cycle wake request instead and the block leaves sleep. A clear strobe and a sleep-entry strobe both restart the watchdog. When the watchdog owns the prescaler, they restart the prescaler too.

The timer counts either a divide-by-4 phase of the system clock or one chosen edge of an external pin. The pin passes through a two-stage synchronizer first. A wrap of the count from all-ones to zero raises a sticky overflow flag, and software clears that flag with its own strobe. The block has no data stream, so every pin is a plain control or status signal.

Top module: `wdog_evt_timer`

## Requirements
- R1: With `pre_to_wdog`=0 and the watchdog enabled, the WDT_BASE-th tick since the last restart produces `rst_req` high for one cycle, one clock after that tick's edge.
- R2: With `pre_to_wdog`=1, expiry takes WDT_BASE*2^`ps_sel` ticks, where `ps_sel` ranges from 0 (1:1) to 7 (1:128).
- R3: While asleep, an expiry raises `wake_req` instead of `rst_req` and ends sleep. `rst_req` and `wake_req` are never high together.
- R4: With `cfg_wdt_en`=0 the watchdog never raises `rst_req` or `wake_req`, whatever the tick, clear and sleep activity.
- R5: `clr_wdog` and `sleep_req` restart the watchdog count. With `pre_to_wdog`=1 they also restart the prescaler, so a full WDT_BASE*2^`ps_sel` ticks are needed afterwards. A strobe in the same cycle as an expiry suppresses that expiry.
- R6: `to_flag` is 1 after reset, after `clr_wdog` and after `sleep_req`. It is 0 from the expiry onwards.
- R7: With `tmr_src`=0 and `pre_to_wdog`=1, the timer advances once every 4 clocks. The first increment lands on the 4th clock edge after reset release.
- R8: With `pre_to_wdog`=0, the timer advances once per 2^(`ps_sel`+1) source events (1:2 to 1:256).
- R9: With `tmr_src`=1, `edge_fall`=0 counts rising edges of `tmr_pin` and `edge_fall`=1 counts falling edges. A pin change shows in the count after the third clock edge.
- R10: A count step from 0xFF to 0x00 sets `tmr_ovf`. It stays set until `ovf_clr`, and a new overflow wins over a clear in the same cycle.
- R11: While asleep, the timer count holds. The clock phase and the pin path are both frozen.
- R12: After reset, `tmr_count`=0, `tmr_ovf`=0, `rst_req`=0, `wake_req`=0 and `to_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_tick | input | 1 | Single-cycle tick enable from the independent watchdog source |
| tmr_pin | input | 1 | External timer input, asynchronous |
| tmr_src | input | 1 | Timer source: 0 = clock/4, 1 = pin |
| edge_fall | input | 1 | Pin edge: 0 = rising, 1 = falling |
| pre_to_wdog | input | 1 | Prescaler owner: 1 = watchdog, 0 = timer |
| ps_sel | input | 3 | Prescaler ratio select |
| cfg_wdt_en | input | 1 | Configuration enable for the watchdog |
| clr_wdog | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Enter-sleep strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| rst_req | output | 1 | Device reset request pulse |
| wake_req | output | 1 | Wake request pulse |
| to_flag | output | 1 | Timeout status, 0 after an expiry |
| tmr_count | output | 8 | Timer count |
| tmr_ovf | output | 1 | Sticky timer overflow flag |

## Verification
The assertions assume that `cfg_wdt_en`, `pre_to_wdog` and `ps_sel` are static configuration, changed only while reset is held. They also assume that `tmr_pin` stays low through reset. The stimulus follows this by programming all configuration inside the reset task. Random values of ratio, owner, edge and pulse count are drawn from a seeded `$urandom` and applied only in a fresh reset. Each expected tick or count is computed from the ratio formulas in the requirements.

// File: rtl/wdog_evt_pkg.sv
package wdog_evt_pkg;
  typedef enum logic {OWN_TMR = 1'b0, OWN_WDOG = 1'b1} pre_owner_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_evt
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else if (!hold) chain[0] <= pin;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else if (!hold) chain[i] <= chain[i-1];
    end
  end

  // cur = last synchronizer stage, prev = one more delay
  assign edge_evt = !hold && (fall_sel ? (!chain[STAGES-1] && chain[STAGES])
                                       : (chain[STAGES-1] && !chain[STAGES]));
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
  parameter int PRE_W = 8,
  localparam int SH_W = $clog2(PRE_W) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            in_evt,
  input  logic [SH_W-1:0] shift,
  output logic            out_evt
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;

  always_comb begin
    one_sh  = (PRE_W+1)'(1) << shift;
    mask    = PRE_W'(one_sh - (PRE_W+1)'(1));
    out_evt = in_evt && !clr && ((cnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (in_evt) cnt <= cnt + PRE_W'(1);
  end

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_evt |-> in_evt);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int WDT_BASE = 1024,
  localparam int CW = (WDT_BASE > 1) ? $clog2(WDT_BASE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr_cmd,
  input  logic sleep_cmd,
  input  logic via_pre,
  input  logic pre_evt,
  output logic base_done,
  output logic asleep,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag
);
  logic [CW-1:0] cnt;
  logic          cmd;
  logic          expire;

  assign cmd       = clr_cmd || sleep_cmd;
  assign base_done = en && tick && !cmd && (cnt == CW'(WDT_BASE-1));
  assign expire    = en && !cmd && (via_pre ? pre_evt : base_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || cmd)       cnt <= '0;
    else if (base_done)        cnt <= '0;
    else if (tick)             cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0; rst_req <= 1'b0; wake_req <= 1'b0; to_flag <= 1'b1;
    end else begin
      rst_req  <= expire && !asleep;
      wake_req <= expire && asleep;
      if (sleep_cmd)   asleep <= 1'b1;
      else if (expire) asleep <= 1'b0;
      if (cmd)         to_flag <= 1'b1;
      else if (expire) to_flag <= 1'b0;
    end
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rst_req && !wake_req));
  p_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> (!rst_req && !wake_req));
  p_tof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> !to_flag);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] count,
  output logic             ovf
);
  logic wrap;
  assign wrap = step && (count == {TMR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0; ovf <= 1'b0;
    end else begin
      if (step) count <= count + TMR_W'(1);
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == {TMR_W{1'b1}}) |=> (ovf && count == '0));
endmodule

// File: rtl/wdog_evt_timer.sv
module wdog_evt_timer
  import wdog_evt_pkg::*;
#(
  parameter int WDT_BASE    = 1024,
  parameter int PRE_W       = 8,
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_DIV     = 4,
  localparam int PS_W = $clog2(PRE_W),
  localparam int SH_W = PS_W + 1,
  localparam int PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_tick,
  input  logic             tmr_pin,
  input  logic             tmr_src,
  input  logic             edge_fall,
  input  logic             pre_to_wdog,
  input  logic [PS_W-1:0]  ps_sel,
  input  logic             cfg_wdt_en,
  input  logic             clr_wdog,
  input  logic             sleep_req,
  input  logic             ovf_clr,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_flag,
  output logic [TMR_W-1:0] tmr_count,
  output logic             tmr_ovf
);
  pre_owner_e      owner;
  logic            asleep, base_done, pre_out, pin_evt, phase_evt, tmr_evt, tmr_step;
  logic [PH_W-1:0] phase;
  logic [SH_W-1:0] shift;

  assign owner = pre_owner_e'(pre_to_wdog);
  assign shift = (owner == OWN_WDOG) ? SH_W'(ps_sel) : SH_W'(ps_sel) + SH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (!asleep) phase <= (phase == PH_W'(CLK_DIV-1)) ? '0 : phase + PH_W'(1);
  end
  assign phase_evt = !asleep && (phase == PH_W'(CLK_DIV-1));

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(asleep), .pin(tmr_pin),
    .fall_sel(edge_fall), .edge_evt(pin_evt));

  assign tmr_evt = tmr_src ? pin_evt : phase_evt;

  shared_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .clr((owner == OWN_WDOG) && (clr_wdog || sleep_req)),
    .in_evt((owner == OWN_WDOG) ? base_done : tmr_evt),
    .shift(shift), .out_evt(pre_out));

  wdog_core #(.WDT_BASE(WDT_BASE)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(cfg_wdt_en), .tick(wdt_tick),
    .clr_cmd(clr_wdog), .sleep_cmd(sleep_req), .via_pre(owner == OWN_WDOG),
    .pre_evt(pre_out), .base_done(base_done), .asleep(asleep),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag));

  assign tmr_step = !asleep && ((owner == OWN_WDOG) ? tmr_evt : pre_out);

  evt_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(tmr_step), .ovf_clr(ovf_clr),
    .count(tmr_count), .ovf(tmr_ovf));

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> $stable(tmr_count));
endmodule

// File: tb/wdog_evt_timer_tb.sv
module wdog_evt_timer_tb;
  localparam int BASE = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wdt_tick = 0, tmr_pin = 0, tmr_src = 0, edge_fall = 0, pre_to_wdog = 1;
  logic [2:0] ps_sel = 0;
  logic cfg_wdt_en = 1, clr_wdog = 0, sleep_req = 0, ovf_clr = 0;
  logic rst_req, wake_req, to_flag, tmr_ovf;
  logic [7:0] tmr_count;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wdog_evt_timer #(.WDT_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .tmr_pin(tmr_pin),
    .tmr_src(tmr_src), .edge_fall(edge_fall), .pre_to_wdog(pre_to_wdog),
    .ps_sel(ps_sel), .cfg_wdt_en(cfg_wdt_en), .clr_wdog(clr_wdog),
    .sleep_req(sleep_req), .ovf_clr(ovf_clr), .rst_req(rst_req),
    .wake_req(wake_req), .to_flag(to_flag), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf));

  function automatic int wd_need(input logic own, input int ps);
    return own ? BASE << ps : BASE;
  endfunction
  function automatic int tmr_expect(input logic own, input int ps, input int evts);
    return own ? evts % 256 : (evts >> (ps + 1)) % 256;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic own, input int ps, input logic src, input logic fall, input logic en);
    rst_n = 0; pre_to_wdog = own; ps_sel = 3'(ps); tmr_src = src;
    edge_fall = fall; cfg_wdt_en = en; tmr_pin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic ticks(input int n, output int rc, output int wc);
    rc = 0; wc = 0;
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1; @(posedge clk); @(negedge clk); wdt_tick = 0;
      rc += int'(rst_req); wc += int'(wake_req);
    end
  endtask

  task automatic strobe(input int which);
    if (which == 0) clr_wdog = 1; else if (which == 1) sleep_req = 1; else ovf_clr = 1;
    @(negedge clk); clr_wdog = 0; sleep_req = 0; ovf_clr = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_pin = 1; repeat (4) @(negedge clk);
      tmr_pin = 0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rc, wc, ps, n, c;
    logic own, fall;
    void'($urandom(32'd2024));
    do_reset(1, 0, 0, 0, 1);
    #1;
    check("R12 count", tmr_count, 0); check("R12 ovf", tmr_ovf, 0);
    check("R12 rst_req", rst_req, 0); check("R12 wake_req", wake_req, 0);
    check("R12 to_flag", to_flag, 1);

    // R1 directed, R6
    do_reset(0, 3, 0, 0, 1);
    ticks(BASE - 1, rc, wc); check("R1 early", rc, 0); check("R6 before", to_flag, 1);
    ticks(1, rc, wc); check("R1 expiry", rc, 1); check("R6 after expiry", to_flag, 0);
    @(negedge clk); check("R1 one cycle", rst_req, 0);
    strobe(0); check("R6 after clear", to_flag, 1);

    // R2 random ratios and owners
    for (int k = 0; k < 6; k++) begin
      ps = int'($urandom_range(0, 4)); own = 1'($urandom_range(0, 1));
      do_reset(own, ps, 0, 0, 1);
      n = wd_need(own, ps);
      ticks(n - 1, rc, wc); check("R2 before", rc, 0);
      ticks(1, rc, wc); check("R2 at ratio", rc, 1);
    end

    // R5 clear restarts prescaler
    do_reset(1, 2, 0, 0, 1);
    ticks(wd_need(1, 2) - 4, rc, wc); strobe(0);
    ticks(wd_need(1, 2) - 1, rc, wc); check("R5 clear restart", rc, 0);
    ticks(1, rc, wc); check("R5 full period", rc, 1);

    // R4 disabled
    do_reset(0, 0, 0, 0, 0);
    ticks(5 * BASE, rc, wc); strobe(1); ticks(5 * BASE, rc, wc);
    check("R4 no reset", rc, 0); check("R4 no wake", wc, 0); check("R4 to_flag", to_flag, 1);

    // R11 freeze and R3 wake
    do_reset(1, 0, 0, 0, 1);
    repeat (40) @(negedge clk);
    strobe(1); c = tmr_count; check("R6 after sleep", to_flag, 1);
    repeat (100) @(negedge clk); check("R11 frozen", tmr_count, c);
    ticks(BASE, rc, wc); check("R3 wake", wc, 1); check("R3 no reset", rc, 0);
    repeat (40) @(negedge clk); check("R11 resumes", tmr_count, c + 10);

    // R7 / R8 internal source
    do_reset(1, 0, 0, 0, 1);
    repeat (400) @(posedge clk); @(negedge clk);
    check("R7 clk/4", tmr_count, 100);
    do_reset(0, 1, 0, 0, 1);
    repeat (400) @(posedge clk); @(negedge clk);
    check("R8 clk/4 prescaled", tmr_count, tmr_expect(0, 1, 100));

    // R9 sync latency
    do_reset(1, 0, 1, 0, 1);
    tmr_pin = 1; @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 not yet", tmr_count, 0);
    @(negedge clk); check("R9 third edge", tmr_count, 1);
    tmr_pin = 0; repeat (4) @(negedge clk);

    // R8/R9 random pin runs
    for (int k = 0; k < 5; k++) begin
      ps = int'($urandom_range(0, 3)); own = 1'($urandom_range(0, 1));
      fall = 1'($urandom_range(0, 1)); n = int'($urandom_range(1, 40));
      do_reset(own, ps, 1, fall, 1);
      pulses(n);
      check(own ? "R9 pin edges" : "R8 pin prescaled", tmr_count, tmr_expect(own, ps, n));
    end

    // R10 overflow
    do_reset(1, 0, 1, 1, 1);
    pulses(255); check("R10 no ovf yet", tmr_ovf, 0);
    pulses(1); check("R10 wrap count", tmr_count, 0); check("R10 ovf set", tmr_ovf, 1);
    repeat (5) @(negedge clk); check("R10 sticky", tmr_ovf, 1);
    strobe(2); check("R10 cleared", tmr_ovf, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule